// File: doc/BRIEF.md
# Vectored Interrupt Controller with Word-Addressed Register Port

This block merges up to 32 interrupt request lines into a single interrupt output for a processor. Each request line is captured into a status register. A line can be level-type, where its status bit mirrors the line, or edge-type, where a rising edge sets its status bit and the bit stays set until software clears it. Which lines are edge-type is fixed by a parameter mask. The status register is masked by an enable register to give the pending set. A priority encoder reports the lowest-numbered pending line as a vector number, so software can dispatch without scanning bits.

Software reaches the block through eight 32-bit registers, selected by a 3-bit word index, with single-cycle read and write strobes. Read data is combinational from the current state. Enables can be set or cleared atomically through two dedicated write-only registers, so a read-modify-write is never needed. Status bits are cleared through a write-only acknowledge register. A two-bit master register gates input capture and the output separately.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Word indices: 0 status, 1 pending, 2 enable, 3 acknowledge, 4 set-enable, 5 clear-enable, 6 vector, 7 master. Reads of indices 3, 4 and 5 return 0. Master reads back its two stored bits, zero-extended. Enable reads back its stored value. Reads return 0 while the read strobe is low.
- R2: Index 1 reads status AND enable, reflecting any register write or capture from the previous clock edge.
- R3: Index 6 reads the index of the lowest-numbered pending bit, zero-extended. Bit 0 has the highest priority. When nothing is pending, index 6 reads 0xFFFFFFFF.
- R4: `irq_out` is registered. It is high in the cycle after a cycle in which master equals 2'b11 and at least one pending bit was set; otherwise it is low.
- R5: While master bit 1 is 0, input lines do not change the status register and `irq_out` is low one cycle later, regardless of master bit 0.
- R6: A write to index 3 clears every status bit whose written bit is 1; other bits are untouched.
- R7: A write to index 4 ORs the written value into enable. A write to index 5 clears every enable bit whose written bit is 1.
- R8: With capture enabled, a level-type status bit equals its input line as sampled at the previous clock edge. By default, lines 0 to 15 are level-type (`EDGE_MASK` = 0xFFFF0000, where bit 1 means edge).
- R9: With capture enabled, a 0-to-1 transition of an edge-type line (lines 16 to 31 by default) sets its status bit. The bit stays set after the line falls, until it is cleared by acknowledge or by a write to index 0.
- R10: Writes to indices 1 and 6 change no stored state.
- R11: If an acknowledge of an edge-type bit and a new rising edge on that line fall in the same cycle, the status bit ends set.
- R12: After reset, status, enable and master are 0, `irq_out` is 0, and the vector reads 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_SRC | Interrupt request lines |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register word index |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data (combinational) |
| irq_out | output | 1 | Interrupt to the processor |

## Verification
A wrong status bit shows at the ports in two ways. It appears on the next read of index 0, 1 or 6, and it appears on `irq_out` exactly one clock later. A corrupted enable bit appears on the next enable or pending read. A wrong priority choice appears as a wrong vector number in the same cycle as the read. Gating faults in the master register appear as `irq_out` rising or staying low one cycle after the offending state. A lost edge capture appears as a status bit that is already clear after the line falls.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
// Package: shared register selector encoding for the interrupt controller.
// The order of selectors is the software-visible word map.
package irqc_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_STATUS  = 3'd0,
        SEL_PENDING = 3'd1,
        SEL_ENABLE  = 3'd2,
        SEL_ACK     = 3'd3,
        SEL_SETEN   = 3'd4,
        SEL_CLREN   = 3'd5,
        SEL_VECTOR  = 3'd6,
        SEL_MASTER  = 3'd7
    } reg_sel_e;

    localparam int MASTER_W = 2;
    localparam int MST_OUT_BIT = 0;
    localparam int MST_CAP_BIT = 1;
endpackage

// File: rtl/irqc_capture.sv
`timescale 1ns/1ps
// Module: irqc_capture
// Captures request lines into the status register. Level-type bits follow
// the line; edge-type bits are set on a rising edge and held until cleared.
// Assumes irq_in is synchronous to clk. Capture has priority over software
// load or acknowledge in the same cycle.
module irqc_capture #(
    parameter int                 NUM_SRC   = 32,
    parameter logic [NUM_SRC-1:0] EDGE_MASK = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               cap_en,
    input  logic               sw_load,
    input  logic               sw_ack,
    input  logic [NUM_SRC-1:0] sw_val,
    output logic [NUM_SRC-1:0] status_q
);
    logic [NUM_SRC-1:0] prev_q;
    logic [NUM_SRC-1:0] rise;
    logic [NUM_SRC-1:0] status_d;

    // Registered copy of the lines for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= irq_in;
    end

    assign rise = irq_in & ~prev_q;

    // Next status: software effect first, then capture on top of it.
    always_comb begin
        status_d = status_q;
        if (sw_load) status_d = sw_val;
        if (sw_ack)  status_d = status_d & ~sw_val;
        if (cap_en) begin
            status_d = (status_d & EDGE_MASK) | (irq_in & ~EDGE_MASK);
            status_d = status_d | (rise & EDGE_MASK);
        end
    end

    // Status register.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end
endmodule

// File: rtl/irqc_ctrl_regs.sv
`timescale 1ns/1ps
// Module: irqc_ctrl_regs
// Decodes register writes. Holds the enable and master registers and
// produces strobes for the status register. Assumes at most one write per
// cycle; writes to read-only selectors are dropped.
module irqc_ctrl_regs
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int DW      = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DW-1:0]       wdata,
    output logic [NUM_SRC-1:0]  enable_q,
    output logic [MASTER_W-1:0] master_q,
    output logic                sw_load,
    output logic                sw_ack,
    output logic [NUM_SRC-1:0]  sw_val
);
    reg_sel_e sel;
    assign sel    = reg_sel_e'(addr);
    assign sw_val = wdata[NUM_SRC-1:0];

    // Strobes toward the status register.
    assign sw_load = wr_en && (sel == SEL_STATUS);
    assign sw_ack  = wr_en && (sel == SEL_ACK);

    // Enable register with direct, set and clear write paths.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_ENABLE: enable_q <= sw_val;
                SEL_SETEN:  enable_q <= enable_q | sw_val;
                SEL_CLREN:  enable_q <= enable_q & ~sw_val;
                default:    enable_q <= enable_q;
            endcase
        end
    end

    // Master register: bit 0 gates the output, bit 1 gates capture.
    always_ff @(posedge clk) begin
        if (!rst_n)                          master_q <= '0;
        else if (wr_en && sel == SEL_MASTER) master_q <= wdata[MASTER_W-1:0];
    end
endmodule

// File: rtl/irqc_prio.sv
`timescale 1ns/1ps
// Module: irqc_prio
// Lowest-index-first priority encoder. Returns the vector word: the
// zero-extended index of the lowest set bit, or all ones when no bit is set.
// Purely combinational.
module irqc_prio #(
    parameter int NUM_SRC = 32,
    parameter int DW      = 32
) (
    input  logic [NUM_SRC-1:0] pend,
    output logic               any,
    output logic [DW-1:0]      vec_word
);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [IDX_W-1:0] idx;

    // Scan from the top so that the lowest set bit is the last assignment.
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                idx = IDX_W'(i);
                any = 1'b1;
            end
        end
    end

    assign vec_word = any ? DW'(idx) : '1;
endmodule

// File: rtl/irq_vector_ctrl.sv
`timescale 1ns/1ps
// Module: irq_vector_ctrl (top)
// Vectored interrupt controller with an eight-word register port. Combines
// request lines into one registered interrupt output. Assumes synchronous
// inputs and NUM_SRC <= DW. Read data is combinational.
module irq_vector_ctrl
    import irqc_pkg::*;
#(
    parameter int                 NUM_SRC   = 32,
    parameter int                 DW        = 32,
    parameter logic [NUM_SRC-1:0] EDGE_MASK = 32'hFFFF_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DW-1:0]      wdata,
    output logic [DW-1:0]      rdata,
    output logic               irq_out
);
    logic [NUM_SRC-1:0]  status_q;
    logic [NUM_SRC-1:0]  enable_q;
    logic [MASTER_W-1:0] master_q;
    logic [NUM_SRC-1:0]  pending;
    logic [NUM_SRC-1:0]  sw_val;
    logic                sw_load;
    logic                sw_ack;
    logic                pend_any;
    logic [DW-1:0]       vec_word;
    logic                irq_q;

    irqc_ctrl_regs #(.NUM_SRC(NUM_SRC), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .enable_q(enable_q), .master_q(master_q),
        .sw_load(sw_load), .sw_ack(sw_ack), .sw_val(sw_val)
    );

    irqc_capture #(.NUM_SRC(NUM_SRC), .EDGE_MASK(EDGE_MASK)) u_cap (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .cap_en(master_q[MST_CAP_BIT]),
        .sw_load(sw_load), .sw_ack(sw_ack), .sw_val(sw_val),
        .status_q(status_q)
    );

    assign pending = status_q & enable_q;

    irqc_prio #(.NUM_SRC(NUM_SRC), .DW(DW)) u_prio (
        .pend(pending), .any(pend_any), .vec_word(vec_word)
    );

    // Registered interrupt output, gated by both master bits.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= master_q[MST_OUT_BIT] & master_q[MST_CAP_BIT] & pend_any;
    end
    assign irq_out = irq_q;

    // Read multiplexer; write-only selectors return zero.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (reg_sel_e'(addr))
                SEL_STATUS:  rdata = DW'(status_q);
                SEL_PENDING: rdata = DW'(pending);
                SEL_ENABLE:  rdata = DW'(enable_q);
                SEL_VECTOR:  rdata = vec_word;
                SEL_MASTER:  rdata = DW'(master_q);
                default:     rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/irqc_checker.sv
`timescale 1ns/1ps
// Module: irqc_checker
// Property checks for irq_vector_ctrl. Attached by bind below.
module irqc_checker
    import irqc_pkg::*;
#(
    parameter int                 NUM_SRC   = 32,
    parameter int                 DW        = 32,
    parameter logic [NUM_SRC-1:0] EDGE_MASK = '0
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_SRC-1:0]  irq_in,
    input logic                wr_en,
    input logic                rd_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [DW-1:0]       wdata,
    input logic [DW-1:0]       rdata,
    input logic                irq_out,
    input logic [NUM_SRC-1:0]  status_q,
    input logic [NUM_SRC-1:0]  enable_q,
    input logic [MASTER_W-1:0] master_q
);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [NUM_SRC-1:0] pend;
    assign pend = status_q & enable_q;

    a_r4_out_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> $past(master_q == 2'b11 && pend != '0));

    a_r4_cause_gives_out: assert property (@(posedge clk) disable iff (!rst_n)
        (master_q == 2'b11 && pend != '0) |=> irq_out);

    a_r5_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
        !master_q[1] |=> !irq_out);

    a_r5_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_q[1] && !wr_en) |=> status_q == $past(status_q));

    a_r7_set_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd4) |=> enable_q == $past(enable_q | wdata[NUM_SRC-1:0]));

    a_r7_clear_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd5) |=> enable_q == $past(enable_q & ~wdata[NUM_SRC-1:0]));

    a_r8_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
        master_q[1] |=> (status_q & ~EDGE_MASK) == ($past(irq_in) & ~EDGE_MASK));

    a_r9_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (addr == 3'd0 || addr == 3'd3))
        |=> (status_q & $past(status_q) & EDGE_MASK) == ($past(status_q) & EDGE_MASK));

    a_r10_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == 3'd1 || addr == 3'd6)) |=> $stable(enable_q) && $stable(master_q));

    a_r3_vector_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd6 && pend != '0)
        |-> pend[rdata[IDX_W-1:0]]
            && ((pend & ((NUM_SRC'(1) << rdata[IDX_W-1:0]) - NUM_SRC'(1))) == '0));

    a_r3_vector_none: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd6 && pend == '0) |-> rdata == '1);
endmodule

bind irq_vector_ctrl irqc_checker #(
    .NUM_SRC(NUM_SRC), .DW(DW), .EDGE_MASK(EDGE_MASK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out),
    .status_q(status_q), .enable_q(enable_q), .master_q(master_q)
);

// File: tb/sim_irq_vector_ctrl.sv
`timescale 1ns/1ps
// Directed bench for irq_vector_ctrl. Edge mask default: lines 16..31 edge.
module sim_irq_vector_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_out;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    irq_vector_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic drive(input logic [31:0] v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R12 irq_out", {31'd0, irq_out}, 32'd0);
        rd(3'd0, d); check("R12 status", d, 32'd0);
        rd(3'd2, d); check("R12 enable", d, 32'd0);
        rd(3'd7, d); check("R12 master", d, 32'd0);
        rd(3'd6, d); check("R12 vector", d, 32'hFFFF_FFFF);
    endtask

    task automatic t_master_gate();
        logic [31:0] d;
        wr(3'd4, 32'h0000_0008);
        drive(32'h0000_0008);
        rd(3'd0, d); check("R5 no capture", d, 32'd0);
        wr(3'd7, 32'h2);
        rd(3'd0, d); check("R5 capture on", d, 32'h8);
        check("R5 out gated", {31'd0, irq_out}, 32'd0);
        wr(3'd7, 32'h1);
        @(negedge clk);
        check("R5 bit1 clear forces low", {31'd0, irq_out}, 32'd0);
        rd(3'd7, d); check("R1 master readback", d, 32'h1);
        drive(32'h0);
        wr(3'd0, 32'h0);
        wr(3'd5, 32'hFFFF_FFFF);
    endtask

    task automatic t_level();
        logic [31:0] d;
        wr(3'd7, 32'h3);
        wr(3'd4, 32'h0000_0018);
        rd(3'd2, d); check("R7 set enable", d, 32'h18);
        drive(32'h0000_0008);
        rd(3'd0, d); check("R8 level set", d, 32'h8);
        rd(3'd1, d); check("R2 pending", d, 32'h8);
        rd(3'd6, d); check("R3 vector 3", d, 32'd3);
        check("R4 irq high", {31'd0, irq_out}, 32'd1);
        drive(32'h0);
        rd(3'd0, d); check("R8 level clear", d, 32'h0);
        rd(3'd6, d); check("R3 vector none", d, 32'hFFFF_FFFF);
        check("R4 irq low", {31'd0, irq_out}, 32'd0);
    endtask

    task automatic t_priority();
        logic [31:0] d;
        drive(32'h0000_0010);
        rd(3'd6, d); check("R3 vector 4", d, 32'd4);
        drive(32'h0000_0018);
        rd(3'd6, d); check("R3 lower wins", d, 32'd3);
        wr(3'd5, 32'h0000_0008);
        rd(3'd2, d); check("R7 clear enable", d, 32'h10);
        rd(3'd6, d); check("R3 after mask", d, 32'd4);
        rd(3'd1, d); check("R2 masked pending", d, 32'h10);
        drive(32'h0);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        wr(3'd4, 32'h0030_0000);
        drive(32'h0010_0000);
        drive(32'h0);
        rd(3'd0, d); check("R9 edge sticky", d, 32'h0010_0000);
        check("R4 irq edge", {31'd0, irq_out}, 32'd1);
        wr(3'd3, 32'h0010_0000);
        rd(3'd0, d); check("R6 ack clears", d, 32'h0);
        check("R4 irq after ack", {31'd0, irq_out}, 32'd0);
        drive(32'h0020_0000);
        wr(3'd3, 32'h0);
        rd(3'd0, d); check("R6 zero ack keeps", d, 32'h0020_0000);
        drive(32'h0);
        @(negedge clk);
        irq_in = 32'h0020_0000; wr_en = 1'b1; addr = 3'd3; wdata = 32'h0020_0000;
        @(negedge clk);
        wr_en = 1'b0;
        rd(3'd0, d); check("R11 edge beats ack", d, 32'h0020_0000);
        drive(32'h0);
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd0, d); check("R6 full ack", d, 32'h0);
    endtask

    task automatic t_readonly();
        logic [31:0] d;
        wr(3'd1, 32'hFFFF_FFFF);
        wr(3'd6, 32'h0);
        rd(3'd2, d); check("R10 enable kept", d, 32'h0030_0010);
        rd(3'd7, d); check("R10 master kept", d, 32'h3);
        rd(3'd0, d); check("R10 status kept", d, 32'h0);
        rd(3'd3, d); check("R1 ack reads 0", d, 32'h0);
        rd(3'd4, d); check("R1 seten reads 0", d, 32'h0);
        rd(3'd5, d); check("R1 clren reads 0", d, 32'h0);
        @(negedge clk); #1;
        check("R1 idle rdata 0", rdata, 32'h0);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_master_gate();
        t_level();
        t_priority();
        t_edge();
        t_readonly();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule